// File: doc/BRIEF.md
# Pulse-Verify Programming Sequencer

This controller writes an image into a one-time-programmable memory whose cells erase to all ones, one word at a time. For each address it raises the programming supply, drives the address and the word, and fires a fixed-width write strobe. It then reads the word back while the margin-read control is held on. If the read-back differs, it fires another strobe. A word that still differs after the permitted number of strobes stops the run with a failure. A word that matches moves the walk to the next address at once; no extra strobe is added after a good read-back.

When the last address has been written, the sequencer reads back the whole array twice, first at a raised supply setting and then at a lowered one. It requests each setting through a two-bit level code and waits for an acknowledge. All setup, hold, strobe and sample intervals are given in microseconds and are turned into clock counts when the block is elaborated, from the clock-frequency parameter. The image comes from outside through `img_data`, which must present the word for `mem_addr`.

Top module: `pv_prog_seq`

## Requirements
- R1: While reset is asserted, and in the cycle after it, `busy`, `done` and `fail` are low, `mem_ce_n` and `mem_oe_n` are high, `mem_vpp_en` is low and `vcc_req` is 0 (rest level). A reset in the middle of a run returns the block to this state.
- R2: Every write strobe keeps `mem_ce_n` low with `mem_oe_n` high for exactly PULSE_US×CLK_MHZ clock cycles.
- R3: `mem_addr` and `mem_wdata` are stable, and `mem_vpp_en` has been high, for at least SETUP_US×CLK_MHZ cycles before a strobe starts. The same three signals stay unchanged, with `mem_ce_n` high, for HOLD_US×CLK_MHZ cycles after the strobe ends.
- R4: A read-back holds `mem_ce_n` and `mem_oe_n` low for exactly SAMPLE_US×CLK_MHZ cycles and samples `mem_rdata` on the last of them. The full word is compared with `img_data`, so a cell that reads 0 where the image has a 1 is a mismatch.
- R5: The strobe count starts from zero at every address. A word that first matches after n strobes receives exactly n strobes, and the walk then moves to the next address.
- R6: When MAX_TRIES (default 25) read-backs of one word have all mismatched, the run stops. `fail` goes high and `fail_addr` holds that address. That address has received exactly MAX_TRIES strobes.
- R7: `mem_margin` is high in every cycle in which `mem_vpp_en` is high, which covers both the strobes and the read-backs of the write phase.
- R8: The supply level codes are 0 for rest, 1 for programming, 2 for the raised check and 3 for the lowered check. After changing `vcc_req`, the block waits for `vcc_ack` to go low and then high before any access, and `mem_ce_n` is never low while `vcc_ack` is low. A passing run requests the levels in the order 1, 2, 3, 0.
- R9: After the write phase, every address is read at level 2 and then at level 3, with `mem_vpp_en` low. The first mismatch ends the run with `fail` high and `fail_addr` set to that address.
- R10: In the cycle after a start in the idle state, `busy` is high and `done` is low. When the run ends, `done` is high and `busy` is low. `done`, `fail` and `fail_addr` then hold until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when the block is idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, whether passed or failed |
| fail | output | 1 | Finished run failed |
| fail_addr | output | ADDR_W | Address of the failing word |
| vcc_req | output | 2 | Requested supply level code |
| vcc_ack | input | 1 | Requested supply level is settled |
| img_data | input | DATA_W | Image word for `mem_addr` |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Word to program |
| mem_rdata | input | DATA_W | Word read back from the memory |
| mem_ce_n | output | 1 | Chip select / write strobe, active low |
| mem_oe_n | output | 1 | Read enable, active low |
| mem_vpp_en | output | 1 | Programming supply on |
| mem_margin | output | 1 | Margin-read control |

## Verification
The assertions check the following on every cycle:
- the strobe width;
- that the address holds while select is low;
- that the programming supply is up before a strobe;
- that no access happens without a supply acknowledge;
- the bound on the strobe counter;
- the relation between the status outputs.

Only the bench's scenarios can show the rest: how many strobes each word receives and where a run stops, because these depend on how the memory model responds. The same holds for the order in which supply levels are requested, for a cell that reads 0 where the image holds a 1, and for a failure that shows up only at one of the two check levels.

// File: rtl/pv_pkg.sv
package pv_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_SUP_DROP, S_SUP_WAIT, S_P_SET, S_P_PULSE,
    S_P_HOLD, S_P_VFY, S_C_SET, S_C_RD, S_END
  } seq_state_t;

  localparam logic [1:0] LVL_REST   = 2'd0;
  localparam logic [1:0] LVL_PROG   = 2'd1;
  localparam logic [1:0] LVL_CHK_HI = 2'd2;
  localparam logic [1:0] LVL_CHK_LO = 2'd3;

  // microseconds to clock cycles, never below one cycle
  function automatic int us_to_cycles(input int us, input int mhz);
    int c;
    c = us * mhz;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pv_phase_timer.sv
module pv_phase_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic [TW-1:0] cnt
);
  // counts cycles spent in the current phase, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (restart)      cnt <= '0;
    else if (cnt != '1)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pv_try_counter.sv
module pv_try_counter #(
  parameter int MAX_TRIES = 25
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last_try
);
  localparam int CW = $clog2(MAX_TRIES + 1);
  logic [CW-1:0] tries;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tries <= '0;
    else if (clr) tries <= '0;
    else if (inc) tries <= tries + 1'b1;
  end

  assign last_try = (tries == CW'(MAX_TRIES - 1));

  AST_TRY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tries < CW'(MAX_TRIES)); // R6
endmodule

// File: rtl/pv_addr_walker.sv
module pv_addr_walker #(
  parameter int ADDR_W = 21,
  parameter logic [ADDR_W-1:0] LAST = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              at_last
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    addr <= '0;
    else if (clr)  addr <= '0;
    else if (step) addr <= addr + 1'b1;
  end

  assign at_last = (addr == LAST);

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> !at_last); // R5
endmodule

// File: rtl/pv_prog_seq.sv
module pv_prog_seq
  import pv_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int DATA_W    = 16,
  parameter int CLK_MHZ   = 125,
  parameter int PULSE_US  = 50,
  parameter int SETUP_US  = 1,
  parameter int HOLD_US   = 2,
  parameter int SAMPLE_US = 1,
  parameter int MAX_TRIES = 25,
  parameter longint LAST_ADDR = (64'd1 << ADDR_W) - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr,
  output logic [1:0]        vcc_req,
  input  logic              vcc_ack,
  input  logic [DATA_W-1:0] img_data,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_vpp_en,
  output logic              mem_margin
);
  localparam int SETUP_CYC  = us_to_cycles(SETUP_US, CLK_MHZ);
  localparam int PULSE_CYC  = us_to_cycles(PULSE_US, CLK_MHZ);
  localparam int HOLD_CYC   = us_to_cycles(HOLD_US, CLK_MHZ);
  localparam int SAMPLE_CYC = us_to_cycles(SAMPLE_US, CLK_MHZ);
  localparam int MAX_CYC    = max2(max2(SETUP_CYC, PULSE_CYC), max2(HOLD_CYC, SAMPLE_CYC));
  localparam int TW         = $clog2(MAX_CYC + 1);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(LAST_ADDR);

  seq_state_t st_q, st_d;
  logic [1:0] lvl_q, lvl_d;
  logic done_q, fail_q, err_q;
  logic [ADDR_W-1:0] fail_addr_q;

  // named internal events
  logic [TW-1:0] ph_cnt, ph_lim;
  logic ph_restart, ph_last, word_match;
  logic try_clr, try_inc, try_last;
  logic a_clr, a_step, a_last;
  logic err_set;

  pv_phase_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(ph_restart), .cnt(ph_cnt));

  pv_try_counter #(.MAX_TRIES(MAX_TRIES)) u_tries (
    .clk(clk), .rst_n(rst_n), .clr(try_clr), .inc(try_inc), .last_try(try_last));

  pv_addr_walker #(.ADDR_W(ADDR_W), .LAST(LAST)) u_addr (
    .clk(clk), .rst_n(rst_n), .clr(a_clr), .step(a_step),
    .addr(mem_addr), .at_last(a_last));

  always_comb begin
    case (st_q)
      S_P_SET, S_C_SET: ph_lim = TW'(SETUP_CYC);
      S_P_PULSE:        ph_lim = TW'(PULSE_CYC);
      S_P_HOLD:         ph_lim = TW'(HOLD_CYC);
      S_P_VFY, S_C_RD:  ph_lim = TW'(SAMPLE_CYC);
      default:          ph_lim = TW'(1);
    endcase
  end

  assign ph_last    = (ph_cnt == ph_lim - 1'b1);
  assign ph_restart = (st_d != st_q);
  assign word_match = (mem_rdata == img_data);

  always_comb begin
    st_d = st_q; lvl_d = lvl_q;
    try_clr = 1'b0; try_inc = 1'b0;
    a_clr = 1'b0; a_step = 1'b0; err_set = 1'b0;
    case (st_q)
      S_IDLE: if (start) begin
        st_d = S_SUP_DROP; lvl_d = LVL_PROG; try_clr = 1'b1; a_clr = 1'b1;
      end
      S_SUP_DROP: if (!vcc_ack) st_d = S_SUP_WAIT;
      S_SUP_WAIT: if (vcc_ack) st_d = (lvl_q == LVL_PROG) ? S_P_SET : S_C_SET;
      S_P_SET:   if (ph_last) st_d = S_P_PULSE;
      S_P_PULSE: if (ph_last) st_d = S_P_HOLD;
      S_P_HOLD:  if (ph_last) st_d = S_P_VFY;
      S_P_VFY: if (ph_last) begin
        if (word_match) begin
          try_clr = 1'b1;
          if (a_last) begin
            a_clr = 1'b1; lvl_d = LVL_CHK_HI; st_d = S_SUP_DROP;
          end else begin
            a_step = 1'b1; st_d = S_P_SET;
          end
        end else if (try_last) begin
          err_set = 1'b1; st_d = S_END;
        end else begin
          try_inc = 1'b1; st_d = S_P_SET;
        end
      end
      S_C_SET: if (ph_last) st_d = S_C_RD;
      S_C_RD: if (ph_last) begin
        if (!word_match) begin
          err_set = 1'b1; st_d = S_END;
        end else if (!a_last) begin
          a_step = 1'b1; st_d = S_C_SET;
        end else if (lvl_q == LVL_CHK_HI) begin
          a_clr = 1'b1; lvl_d = LVL_CHK_LO; st_d = S_SUP_DROP;
        end else begin
          st_d = S_END;
        end
      end
      S_END: begin lvl_d = LVL_REST; st_d = S_IDLE; end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; lvl_q <= LVL_REST;
      done_q <= 1'b0; fail_q <= 1'b0; err_q <= 1'b0; fail_addr_q <= '0;
    end else begin
      st_q <= st_d; lvl_q <= lvl_d;
      if (st_q == S_IDLE && start) begin
        done_q <= 1'b0; fail_q <= 1'b0; err_q <= 1'b0;
      end
      if (err_set) begin
        err_q <= 1'b1; fail_addr_q <= mem_addr;
      end
      if (st_q == S_END) begin
        done_q <= 1'b1; fail_q <= err_q;
      end
    end
  end

  assign busy       = (st_q != S_IDLE);
  assign done       = done_q;
  assign fail       = fail_q;
  assign fail_addr  = fail_addr_q;
  assign vcc_req    = lvl_q;
  assign mem_wdata  = img_data;
  assign mem_ce_n   = !(st_q inside {S_P_PULSE, S_P_VFY, S_C_RD});
  assign mem_oe_n   = !(st_q inside {S_P_VFY, S_C_RD});
  assign mem_vpp_en = st_q inside {S_P_SET, S_P_PULSE, S_P_HOLD, S_P_VFY};
  assign mem_margin = st_q inside {S_P_SET, S_P_PULSE, S_P_HOLD, S_P_VFY};

  // checker-side strobe length counter
  logic [TW-1:0] strobe_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     strobe_run <= '0;
    else if (!mem_ce_n && mem_oe_n) strobe_run <= strobe_run + 1'b1;
    else                            strobe_run <= '0;
  end

  AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(mem_ce_n) && $past(mem_oe_n)) |-> strobe_run == TW'(PULSE_CYC)); // R2
  AST_ADDR_HELD_CE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr)); // R3
  AST_VPP_BEFORE_CE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ce_n) && mem_oe_n) |-> $past(mem_vpp_en)); // R3
  AST_READ_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_oe_n) && mem_vpp_en) |-> $past(mem_ce_n)); // R4
  AST_CE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> vcc_ack); // R8
  AST_CHECK_NO_VPP: assert property (@(posedge clk) disable iff (!rst_n)
    (vcc_req == LVL_CHK_HI || vcc_req == LVL_CHK_LO) |-> !mem_vpp_en); // R9
  AST_FAIL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
endmodule

// File: tb/sim_pv_prog_seq.sv
module sim_pv_prog_seq;
  localparam int SETUP = 2, PULSE = 100, HOLD = 4, SAMPLE = 2; // at CLK_MHZ=2

  typedef struct packed {
    logic [4:0] n0, n1, n2, n3;  // strobes each word needs
    logic       bad_en;
    logic [1:0] bad_a;           // word with a cell stuck at 0 on bit 0
    logic [1:0] weak_lvl;        // level code at which a word reads bit 15 flipped
    logic [1:0] weak_a;
    logic       exp_fail;
    logic [1:0] exp_fa;
    logic [7:0] exp_pulses;
    logic [7:0] exp_hist;        // last four level codes requested
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VT [NV] = '{
    '{5'd1, 5'd1, 5'd1, 5'd1, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 8'd4,  8'h6C},
    '{5'd3, 5'd1, 5'd7, 5'd2, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 8'd13, 8'h6C},
    '{5'd1, 5'd1, 5'd25,5'd1, 1'b0, 2'd0, 2'd0, 2'd0, 1'b0, 2'd0, 8'd28, 8'h6C},
    '{5'd1, 5'd26,5'd1, 5'd1, 1'b0, 2'd0, 2'd0, 2'd0, 1'b1, 2'd1, 8'd26, 8'h04},
    '{5'd1, 5'd1, 5'd1, 5'd1, 1'b1, 2'd3, 2'd0, 2'd0, 1'b1, 2'd3, 8'd28, 8'h04},
    '{5'd1, 5'd1, 5'd1, 5'd1, 1'b0, 2'd0, 2'd2, 2'd2, 1'b1, 2'd2, 8'd4,  8'h18},
    '{5'd1, 5'd1, 5'd1, 5'd1, 1'b0, 2'd0, 2'd3, 2'd1, 1'b1, 2'd1, 8'd4,  8'h6C}
  };
  localparam logic [15:0] IMG [4] = '{16'h1234, 16'h0F0F, 16'h0000, 16'hA5A5};

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic busy, done, fail, vcc_ack, mem_ce_n, mem_oe_n, mem_vpp_en, mem_margin;
  logic [1:0] fail_addr, vcc_req, mem_addr;
  logic [15:0] img_data, mem_wdata, mem_rdata;

  always #4 clk = ~clk; // 125 MHz

  pv_prog_seq #(.ADDR_W(2), .DATA_W(16), .CLK_MHZ(2)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .fail(fail), .fail_addr(fail_addr), .vcc_req(vcc_req), .vcc_ack(vcc_ack),
    .img_data(img_data), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_vpp_en(mem_vpp_en), .mem_margin(mem_margin));

  // supply model: ack drops on a change, rises after 3 stable cycles
  logic [1:0] req_d;
  logic [2:0] stab;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin req_d <= 2'd0; stab <= 3'd0; end
    else begin
      req_d <= vcc_req;
      stab  <= (vcc_req != req_d) ? 3'd0 : ((stab < 3'd7) ? stab + 3'd1 : stab);
    end
  end
  assign vcc_ack = (vcc_req == req_d) && (stab >= 3'd3);

  // memory model
  vec_t cur = VT[0];
  logic [7:0] prog_cnt [4];
  logic [4:0] need;
  logic [15:0] rd;
  assign img_data = IMG[mem_addr];
  always_comb begin
    case (mem_addr)
      2'd0: need = cur.n0;
      2'd1: need = cur.n1;
      2'd2: need = cur.n2;
      default: need = cur.n3;
    endcase
    rd = (prog_cnt[mem_addr] >= {3'b0, need}) ? IMG[mem_addr] : 16'hFFFF;
    if (cur.bad_en && mem_addr == cur.bad_a) rd = rd & 16'hFFFE;
    if (cur.weak_lvl != 2'd0 && vcc_req == cur.weak_lvl && mem_addr == cur.weak_a)
      rd = rd ^ 16'h8000;
    mem_rdata = rd;
  end

  // protocol monitor
  int nchk = 0, nerr = 0;
  int pulses = 0, pw = 0, rw = 0, hold_left = 0, addr_age = 0, vpp_run = 0;
  int v_setup = 0, v_hold = 0, v_pw = 0, v_rd = 0, v_margin = 0, v_ack = 0;
  logic [7:0] hist = 8'h0;
  logic p_pulse = 1'b0, p_read = 1'b0;
  logic [1:0] p_addr = 2'd0, p_vcc = 2'd0;
  logic [15:0] p_wdata = 16'h0;

  initial for (int a = 0; a < 4; a++) prog_cnt[a] = 8'd0;

  always @(negedge clk) if (rst_n) begin
    automatic logic pnow = !mem_ce_n && mem_oe_n;
    automatic logic rnow = !mem_ce_n && !mem_oe_n;
    addr_age = (mem_addr != p_addr) ? 0 : addr_age + 1;
    vpp_run  = mem_vpp_en ? vpp_run + 1 : 0;
    if (pnow && !p_pulse) begin
      if (addr_age < SETUP) v_setup++;
      if (vpp_run < SETUP + 1) v_setup++;
    end
    if (pnow) pw++;
    else if (p_pulse) begin
      if (pw != PULSE) v_pw++;
      pw = 0; prog_cnt[p_addr] = prog_cnt[p_addr] + 8'd1; pulses++;
      hold_left = HOLD;
    end
    if (hold_left > 0 && !pnow) begin
      if (!mem_ce_n || !mem_vpp_en || mem_addr != p_addr || mem_wdata != p_wdata) v_hold++;
      hold_left--;
    end
    if (rnow) rw++;
    else if (p_read) begin if (rw != SAMPLE) v_rd++; rw = 0; end
    if (mem_vpp_en && !mem_margin) v_margin++;
    if (!mem_ce_n && !vcc_ack) v_ack++;
    if (vcc_req != p_vcc) hist = {hist[5:0], vcc_req};
    p_pulse = pnow; p_read = rnow; p_addr = mem_addr; p_vcc = vcc_req; p_wdata = mem_wdata;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  task automatic run_vec(input int i);
    cur = VT[i];
    for (int a = 0; a < 4; a++) prog_cnt[a] = 8'd0;
    @(negedge clk);
    hist = 8'h0; pulses = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 busy after start", {31'b0, busy}, 1);
    chk("R10 done cleared", {31'b0, done}, 0);
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R6/R9 fail flag", {31'b0, fail}, {31'b0, cur.exp_fail});
    if (cur.exp_fail) chk("R6/R9 fail_addr", {30'b0, fail_addr}, {30'b0, cur.exp_fa});
    chk("R5/R6 strobe total", pulses, {24'b0, cur.exp_pulses});
    chk("R8 level order", {24'b0, hist}, {24'b0, cur.exp_hist});
    chk("R8 rest level at end", {30'b0, vcc_req}, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {31'b0, busy}, 0);
    chk("R1 reset ce_n", {31'b0, mem_ce_n}, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle done/fail", {30'b0, done, fail}, 0);
    chk("R1 idle oe_n/vpp", {30'b0, mem_oe_n, mem_vpp_en}, 2);
    chk("R1 idle vcc_req", {30'b0, vcc_req}, 0);

    for (int i = 0; i < NV; i++) run_vec(i);

    chk("R2 strobe width violations", v_pw, 0);
    chk("R3 setup violations", v_setup, 0);
    chk("R3 hold violations", v_hold, 0);
    chk("R4 read window violations", v_rd, 0);
    chk("R7 margin violations", v_margin, 0);
    chk("R8 access without ack", v_ack, 0);

    repeat (10) @(negedge clk);
    chk("R10 status held", {28'b0, done, fail, fail_addr}, {28'b0, 1'b1, 1'b1, 2'd1});
    chk("R10 idle not busy", {31'b0, busy}, 0);

    // reset in the middle of a strobe
    cur = VT[0];
    for (int a = 0; a < 4; a++) prog_cnt[a] = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    chk("R2 strobe active before reset", {31'b0, mem_ce_n}, 0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 mid-run reset outputs", {27'b0, busy, done, mem_ce_n, mem_vpp_en, mem_oe_n}, 5'b00101);
    chk("R1 mid-run reset level", {30'b0, vcc_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    summary();
    $finish;
  end
endmodule